// File: doc/BRIEF.md
# Wordline Driver Power Wake Sequencer

This block gates the power of the wordline drivers in one segment of a memory array. One instance serves a group of 128 rows. It drives two switch enables. The main-supply switch precharges the driver rail. The regulated-supply switch then lifts the rail to its working level. Because the two stages always happen in that order, the regulator never carries the full inrush current.

A wake request starts the sequence:

1. The main-supply enable rises.
2. After a precharge count, the regulated-supply enable rises.
3. After a settle count, the ready flag rises.

A sleep request runs the stages in reverse. The regulated switch opens first and the main switch opens one cycle later. Access requests from the segment's users pass through while ready is high and are held off while it is low.

The precharge and settle lengths are parameters counted in clock cycles. An elaboration check compares their sum, multiplied by the clock period parameter, against a 100 ns wake budget.

Top module: `wl_wake_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `main_en`, `reg_en` and `ready` are low and every `acc_go` bit is low.
- R2: When `wake_req` is sampled high with `sleep_req` low while the segment is off, `main_en` is high in the next cycle and `reg_en` is still low.
- R3: `reg_en` rises exactly PRE_CYC cycles after `main_en` rises. It never rises in the same cycle as `main_en`, and it is never high while `main_en` is low.
- R4: `ready` rises exactly SET_CYC cycles after `reg_en` rises. It is high only while both enables are high.
- R5: From the clock edge that samples the wake request to the rise of `ready` takes PRE_CYC+SET_CYC cycles. The design refuses to elaborate when this times CLK_PERIOD_PS is not below WAKE_BUDGET_PS.
- R6: A sampled `sleep_req` drops `reg_en` and `ready` in the next cycle while `main_en` stays high for that one cycle. `main_en` falls in the following cycle.
- R7: When `wake_req` and `sleep_req` are sampled together, the sleep request wins. From off nothing changes, and from any powered state the sleep sequence of R6 runs.
- R8: A wake request sampled in the cycle where only the main switch is still on after a sleep restarts the sequence from precharge. `main_en` stays high, and `reg_en` rises PRE_CYC cycles later.
- R9: A sleep request during precharge or settle aborts the wake. `ready` never rises, `reg_en` is low the next cycle, and `main_en` falls one cycle after that.
- R10: For each port i, `acc_go[i]` equals `acc_req[i]` while `ready` is high and is 0 otherwise. `acc_stall[i]` equals `acc_req[i]` while `ready` is low and is 0 otherwise. There is no cycle of delay.
- R11: `wake_req` is ignored while the segment is waking or awake, so the timing in progress is kept. `sleep_req` is ignored while the segment is fully off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Request to power the segment up |
| sleep_req | input | 1 | Request to power the segment down |
| acc_req | input | NUM_PORTS | Access requests to the segment |
| main_en | output | 1 | Main-supply switch enable |
| reg_en | output | 1 | Regulated-supply switch enable |
| ready | output | 1 | Segment powered and usable |
| acc_go | output | NUM_PORTS | Access requests passed through |
| acc_stall | output | NUM_PORTS | Access requests held off |

## Verification
Most internal faults in this block show up at the ports as timing faults. A wrong phase or an off-by-one precharge or settle counter moves the rise of `reg_en` or `ready` by at least one cycle, and the per-cycle comparison catches it on the first misplaced edge. A wrong decode of the sleep drain shows up in the same cycle as a collapse of the two-step shutdown: both enables fall together, or `main_en` stays high too long. A phase that ignores a request stays wrong until the next request, so the random phase mixes short wake and sleep gaps to expose it within a few cycles.

// File: rtl/wl_wake_pkg.sv
package wl_wake_pkg;

  // Power phase of one wordline segment.
  // DRAIN holds the main switch alone for one cycle after the regulated switch opens.
  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_PRECH  = 3'd1,
    PH_SETTLE = 3'd2,
    PH_ON     = 3'd3,
    PH_DRAIN  = 3'd4
  } wl_phase_e;

endpackage

// File: rtl/wl_wake_timer.sv
module wl_wake_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/wl_wake_ctrl.sv
module wl_wake_ctrl
  import wl_wake_pkg::*;
#(
  parameter int PRE_CYC = 8,
  parameter int SET_CYC = 16,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake_req,
  input  logic          sleep_req,
  input  logic          expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output wl_phase_e     phase,
  output logic          main_en,
  output logic          reg_en,
  output logic          ready
);

  localparam logic [CW-1:0] PRE_LD = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] SET_LD = CW'(SET_CYC - 1);

  wl_phase_e ph_q;
  wl_phase_e ph_d;

  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (ph_q)
      PH_OFF: begin
        if (wake_req && !sleep_req) begin
          ph_d     = PH_PRECH;
          tmr_load = 1'b1;
          tmr_val  = PRE_LD;
        end
      end
      PH_PRECH: begin
        if (sleep_req) begin
          ph_d = PH_DRAIN;
        end else if (expired) begin
          ph_d     = PH_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = SET_LD;
        end
      end
      PH_SETTLE: begin
        if (sleep_req) begin
          ph_d = PH_DRAIN;
        end else if (expired) begin
          ph_d = PH_ON;
        end
      end
      PH_ON: begin
        if (sleep_req) begin
          ph_d = PH_DRAIN;
        end
      end
      PH_DRAIN: begin
        if (wake_req && !sleep_req) begin
          ph_d     = PH_PRECH;
          tmr_load = 1'b1;
          tmr_val  = PRE_LD;
        end else begin
          ph_d = PH_OFF;
        end
      end
      default: ph_d = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_OFF;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign phase   = ph_q;
  assign main_en = (ph_q != PH_OFF);
  assign reg_en  = (ph_q == PH_SETTLE) || (ph_q == PH_ON);
  assign ready   = (ph_q == PH_ON);

endmodule

// File: rtl/wl_wake_gate.sv
module wl_wake_gate #(
  parameter int NUM_PORTS = 2
) (
  input  logic                 ready,
  input  logic [NUM_PORTS-1:0] acc_req,
  output logic [NUM_PORTS-1:0] acc_go,
  output logic [NUM_PORTS-1:0] acc_stall
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign acc_go[i]    = acc_req[i] &  ready;
    assign acc_stall[i] = acc_req[i] & ~ready;
  end

endmodule

// File: rtl/wl_wake_seq.sv
module wl_wake_seq
  import wl_wake_pkg::*;
#(
  parameter int PRE_CYC        = 8,
  parameter int SET_CYC        = 16,
  parameter int CLK_PERIOD_PS  = 2000,
  parameter int WAKE_BUDGET_PS = 100000,
  parameter int NUM_PORTS      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wake_req,
  input  logic                 sleep_req,
  input  logic [NUM_PORTS-1:0] acc_req,
  output logic                 main_en,
  output logic                 reg_en,
  output logic                 ready,
  output logic [NUM_PORTS-1:0] acc_go,
  output logic [NUM_PORTS-1:0] acc_stall
);

  localparam int MAX_CYC = (PRE_CYC > SET_CYC) ? PRE_CYC : SET_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  if (PRE_CYC < 1 || SET_CYC < 1) begin : g_bad_len
    $error("wl_wake_seq: both stage lengths must be at least one cycle");
  end
  if ((PRE_CYC + SET_CYC) * CLK_PERIOD_PS >= WAKE_BUDGET_PS) begin : g_bad_budget
    $error("wl_wake_seq: wake sequence exceeds the wake time budget");
  end

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;
  wl_phase_e     phase;

  wl_wake_timer #(
    .CW(CW)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  wl_wake_ctrl #(
    .PRE_CYC(PRE_CYC),
    .SET_CYC(SET_CYC),
    .CW     (CW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_req (wake_req),
    .sleep_req(sleep_req),
    .expired  (tmr_expired),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .phase    (phase),
    .main_en  (main_en),
    .reg_en   (reg_en),
    .ready    (ready)
  );

  wl_wake_gate #(
    .NUM_PORTS(NUM_PORTS)
  ) u_gate (
    .ready    (ready),
    .acc_req  (acc_req),
    .acc_go   (acc_go),
    .acc_stall(acc_stall)
  );

endmodule

// File: rtl/wl_wake_chk.sv
module wl_wake_chk
  import wl_wake_pkg::*;
#(
  parameter int PRE_CYC   = 8,
  parameter int SET_CYC   = 16,
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wake_req,
  input logic                 sleep_req,
  input logic [NUM_PORTS-1:0] acc_req,
  input logic                 main_en,
  input logic                 reg_en,
  input logic                 ready,
  input logic [NUM_PORTS-1:0] acc_go,
  input logic [NUM_PORTS-1:0] acc_stall,
  input wl_phase_e            phase
);

  localparam int WAKE_CYC = PRE_CYC + SET_CYC;

  logic        in_wake;
  logic [15:0] wk_q;

  assign in_wake = (phase == PH_PRECH) || (phase == PH_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_q <= '0;
    end else if (in_wake) begin
      wk_q <= wk_q + 16'd1;
    end else begin
      wk_q <= '0;
    end
  end

  // R2
  wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !sleep_req && !main_en) |=> (main_en && !reg_en));

  // R3
  main_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en) |-> $past(main_en));

  // R3
  no_joint_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_en) |-> !reg_en);

  // R3
  reg_needs_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |-> main_en);

  // R4
  ready_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (main_en && reg_en));

  // R5
  wake_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wake |-> (int'(wk_q) < WAKE_CYC));

  // R6
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && ready) |=> (!ready && !reg_en && main_en));

  // R6
  reg_opens_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_en) |-> !$past(reg_en));

  // R10
  go_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|acc_go) |-> ready);

  // R10
  req_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_go | acc_stall) == acc_req) && ((acc_go & acc_stall) == '0));

  // R11
  awake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !sleep_req) |=> ready);

endmodule

bind wl_wake_seq wl_wake_chk #(
  .PRE_CYC  (PRE_CYC),
  .SET_CYC  (SET_CYC),
  .NUM_PORTS(NUM_PORTS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wake_req (wake_req),
  .sleep_req(sleep_req),
  .acc_req  (acc_req),
  .main_en  (main_en),
  .reg_en   (reg_en),
  .ready    (ready),
  .acc_go   (acc_go),
  .acc_stall(acc_stall),
  .phase    (phase)
);

// File: tb/wl_wake_seq_tb.sv
module wl_wake_seq_tb;

  localparam int PRE = 8;
  localparam int SET = 16;
  localparam int NP  = 2;

  logic          clk;
  logic          rst_n;
  logic          wake_req;
  logic          sleep_req;
  logic [NP-1:0] acc_req;
  logic          main_en;
  logic          reg_en;
  logic          ready;
  logic [NP-1:0] acc_go;
  logic [NP-1:0] acc_stall;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model state
  bit m_main;
  bit m_reg;
  bit m_rdy;
  bit m_drain;
  int m_t;

  wl_wake_seq #(
    .PRE_CYC  (PRE),
    .SET_CYC  (SET),
    .NUM_PORTS(NP)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_req (wake_req),
    .sleep_req(sleep_req),
    .acc_req  (acc_req),
    .main_en  (main_en),
    .reg_en   (reg_en),
    .ready    (ready),
    .acc_go   (acc_go),
    .acc_stall(acc_stall)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse(input bit w, input bit s);
    wake_req  = w;
    sleep_req = s;
    tick(1);
    wake_req  = 1'b0;
    sleep_req = 1'b0;
  endtask

  // Model: timing described in cycles since the main switch came on.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_main = 0; m_reg = 0; m_rdy = 0; m_drain = 0; m_t = 0;
    end else if (sleep_req) begin
      if (m_drain) begin
        m_main = 0; m_drain = 0;
      end else if (m_main) begin
        m_reg = 0; m_rdy = 0; m_drain = 1;
      end
    end else if (wake_req && (!m_main || m_drain)) begin
      m_main = 1; m_drain = 0; m_reg = 0; m_rdy = 0; m_t = 0;
    end else if (m_drain) begin
      m_main = 0; m_drain = 0;
    end else if (m_main) begin
      if (m_t < 1000) m_t++;
      m_reg = (m_t >= PRE);
      m_rdy = (m_t >= PRE + SET);
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(main_en == m_main, "R2 main_en", main_en, m_main);
      chk(reg_en == m_reg, "R3 reg_en", reg_en, m_reg);
      chk(ready == m_rdy, "R4 ready", ready, m_rdy);
      chk(acc_go == (m_rdy ? acc_req : '0), "R10 acc_go", acc_go, m_rdy ? acc_req : 0);
      chk(acc_stall == (m_rdy ? '0 : acc_req), "R10 acc_stall", acc_stall, m_rdy ? 0 : acc_req);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    wake_req  = 1'b0;
    sleep_req = 1'b0;
    acc_req   = '0;
    tick(3);
    // R1
    chk(!main_en && !reg_en && !ready, "R1 reset outputs", {main_en, reg_en, ready}, 0);
    acc_req = 2'b11;
    #1;
    chk(acc_go == '0, "R1 acc_go in reset", acc_go, 0);
    acc_req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    chk(!main_en && !ready, "R1 after release", {main_en, ready}, 0);

    // R2, R3, R4, R5: full wake timing
    pulse(1, 0);
    chk(main_en == 1'b1, "R2 main on", main_en, 1);
    chk(reg_en == 1'b0, "R2 reg still off", reg_en, 0);
    tick(PRE - 1);
    chk(reg_en == 1'b0, "R3 reg off before precharge end", reg_en, 0);
    tick(1);
    chk(reg_en == 1'b1, "R3 reg on after precharge", reg_en, 1);
    tick(SET - 1);
    chk(ready == 1'b0, "R4 ready off before settle end", ready, 0);
    tick(1);
    chk(ready == 1'b1, "R5 ready after PRE+SET cycles", ready, 1);

    // R11: wake while awake ignored
    pulse(1, 0);
    chk(ready == 1'b1, "R11 wake ignored when awake", ready, 1);

    // R10
    acc_req = 2'b10;
    #1;
    chk(acc_go == 2'b10 && acc_stall == 2'b00, "R10 pass when ready", acc_go, 2);

    // R6
    acc_req = '0;
    pulse(0, 1);
    chk(!ready && !reg_en, "R6 reg and ready drop", {reg_en, ready}, 0);
    chk(main_en == 1'b1, "R6 main held one cycle", main_en, 1);
    tick(1);
    chk(main_en == 1'b0, "R6 main drops next cycle", main_en, 0);
    acc_req = 2'b11;
    #1;
    chk(acc_stall == 2'b11 && acc_go == 2'b00, "R10 stall when off", acc_stall, 3);
    acc_req = '0;

    // R11: sleep while off ignored
    pulse(0, 1);
    chk(!main_en && !reg_en, "R11 sleep ignored when off", main_en, 0);

    // R7: both from off
    pulse(1, 1);
    chk(main_en == 1'b0, "R7 sleep wins from off", main_en, 0);

    // R9: abort in precharge
    pulse(1, 0);
    tick(3);
    pulse(0, 1);
    chk(main_en && !reg_en && !ready, "R9 precharge abort", {main_en, reg_en}, 2);
    tick(1);
    chk(main_en == 1'b0, "R9 main off after abort", main_en, 0);

    // R9: abort in settle
    pulse(1, 0);
    tick(PRE + 2);
    chk(reg_en == 1'b1, "R9 in settle", reg_en, 1);
    pulse(0, 1);
    chk(main_en && !reg_en && !ready, "R9 settle abort", {main_en, reg_en}, 2);
    tick(1);
    chk(main_en == 1'b0, "R9 main off after settle abort", main_en, 0);

    // R7 from on, then R8 restart during drain
    pulse(1, 0);
    tick(PRE + SET);
    chk(ready == 1'b1, "R7 awake before joint request", ready, 1);
    pulse(1, 1);
    chk(!ready && !reg_en && main_en, "R7 sleep wins from on", {main_en, reg_en}, 2);
    pulse(1, 0);
    chk(main_en && !reg_en, "R8 restart keeps main", {main_en, reg_en}, 2);
    tick(PRE - 1);
    chk(reg_en == 1'b0, "R8 reg off before restart precharge end", reg_en, 0);
    tick(1);
    chk(reg_en == 1'b1, "R8 reg on after restart precharge", reg_en, 1);
    tick(SET);
    chk(ready == 1'b1, "R8 ready after restart", ready, 1);

    // Mixed traffic, checked against the model every cycle
    for (int i = 0; i < 600; i++) begin
      wake_req  = ($urandom % 6) == 0;
      sleep_req = ($urandom % 20) == 0;
      acc_req   = NP'($urandom);
      tick(1);
    end
    wake_req  = 1'b0;
    sleep_req = 1'b0;
    acc_req   = '0;
    tick(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule